// File: doc/BRIEF.md
# Byte-Swapping Data Port for a Serial-Bus Controller

This block sits between a 16-bit register data port and a four-byte holding buffer inside a two-wire serial-bus controller. A CPU write of a 16-bit word appends two bytes to the buffer. A byte-wide write appends one byte, and it may only end a message. A CPU read takes up to two of the oldest bytes and returns them as one 16-bit word. One byte-order input decides which lane of the 16-bit word carries the older byte. This applies to reads and to writes.

The transfer sequencer on the other side of the buffer appends received bytes one at a time and removes transmit bytes one at a time. The block keeps the fill level. It also keeps six status flags that the data port touches: access-ready, receive-ready, transmit-ready, transmit-underflow, receive-overrun and access-error. It raises a one-cycle kick to the sequencer after every CPU access. It leaves the serial protocol and interrupt generation to other blocks.

Top module: `i2c_dport`

## Requirements
- R1: After reset, `level` is 0, `stat` is 0, `rd_data` is 0, and `kick` and `master_clr` are low.
- R2: An accepted 16-bit write appends two bytes behind the stored ones. When `big_endian` is 0, `wr_data[7:0]` is placed first and `wr_data[15:8]` second. When `big_endian` is 1, the order is reversed. `level` rises by 2.
- R3: An accepted byte-wide write (`wr_byte`=1) appends only `wr_data[7:0]` and raises `level` by 1. After it, every CPU write is dropped until `level` returns to 0.
- R4: A write is dropped in two cases: when the free space (4 minus `level`) is smaller than the bytes it carries, or while the buffer is locked under R3. A dropped write leaves the buffer and `level` unchanged and sets access-error (`stat[5]`).
- R5: A read returns the two oldest bytes b0 and b1 in `rd_data` one cycle later. The word is {b1,b0} when `big_endian` is 0 and {b0,b1} when it is 1. A missing b1 reads as 0. The read consumes min(`level`,2) bytes, and the remaining bytes move down to the oldest positions.
- R6: A read with `level`=0 returns 0 and sets access-error (`stat[5]`).
- R7: Any read clears receive-ready (`stat[1]`) and receive-overrun (`stat[4]`). When `is_master`=1 and `tx_dir`=0, the read also sets access-ready (`stat[0]`) and pulses `master_clr` for one cycle.
- R8: An accepted write clears transmit-transmit flags as follows: transmit-underflow (`stat[3]`) and transmit-ready (`stat[2]`).
- R9: `kick` is high for exactly the cycle after each cycle in which `wr_en` or `rd_en` is high, and low otherwise.
- R10: `rx_push` appends `rx_byte` when `level`<4. `tx_pop` removes the oldest byte when `level`>0. `tx_byte` always shows the oldest byte. Both are ignored in a cycle that has a CPU access. `level` never exceeds 4.
- R11: Each cycle the flags become (old & ~`stat_clr`) | `stat_set`. The effects of a CPU access in the same cycle override this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Lane order: 1 puts the older byte in the upper lane |
| is_master | input | 1 | Controller is bus master |
| tx_dir | input | 1 | Transfer direction, 1 = transmit |
| wr_en | input | 1 | CPU write strobe |
| wr_byte | input | 1 | Write is byte-wide (final byte of a message) |
| wr_data | input | 16 | CPU write data |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 16 | Word returned by the last read |
| rx_push | input | 1 | Sequencer appends a received byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Sequencer removes the oldest byte |
| tx_byte | output | 8 | Oldest buffered byte |
| level | output | 3 | Bytes held in the buffer |
| stat_set | input | 6 | Flag set requests |
| stat_clr | input | 6 | Flag clear requests |
| stat | output | 6 | Flags: 0 access-ready, 1 receive-ready, 2 transmit-ready, 3 transmit-underflow, 4 receive-overrun, 5 access-error |
| master_clr | output | 1 | One-cycle request to drop master mode |
| kick | output | 1 | One-cycle request for the sequencer to run |

## Verification
Every result is registered once, so all of them are due one cycle after the stimulus. This covers `rd_data`, `level`, `stat`, `kick` and `master_clr`. `tx_byte` follows `level` with no added delay. The bench drives inputs just after a falling edge and holds them across one rising edge. It reads every result at the next falling edge, so each check falls half a period after the register that produces it. Sweeps run over both lane orders, every starting fill level from 0 to 4, and word and byte writes. Each of these cases ends by draining the buffer byte by byte against a bench-side byte queue.

// File: rtl/i2c_dport_pkg.sv
package i2c_dport_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = 2 * LANE_W;

  localparam int unsigned ST_ARDY = 0;
  localparam int unsigned ST_RRDY = 1;
  localparam int unsigned ST_XRDY = 2;
  localparam int unsigned ST_XUDF = 3;
  localparam int unsigned ST_ROVR = 4;
  localparam int unsigned ST_AERR = 5;
  localparam int unsigned ST_W    = 6;

  // Byte taken first from a written word.
  function automatic logic [LANE_W-1:0] lane_first(input logic [WORD_W-1:0] w, input logic big);
    return big ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0];
  endfunction

  // Byte taken second from a written word.
  function automatic logic [LANE_W-1:0] lane_second(input logic [WORD_W-1:0] w, input logic big);
    return big ? w[LANE_W-1:0] : w[WORD_W-1:LANE_W];
  endfunction

  // Word formed from the oldest byte and the one after it.
  function automatic logic [WORD_W-1:0] word_of(input logic [LANE_W-1:0] older,
                                                input logic [LANE_W-1:0] newer,
                                                input logic big);
    return big ? {older, newer} : {newer, older};
  endfunction
endpackage

// File: rtl/i2c_dport_buf.sv
module i2c_dport_buf #(
  parameter int unsigned DEPTH = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0]                             pop_n,
  input  logic [1:0]                             push_n,
  input  logic [i2c_dport_pkg::LANE_W-1:0]       push_a,
  input  logic [i2c_dport_pkg::LANE_W-1:0]       push_b,
  output logic [DEPTH-1:0][i2c_dport_pkg::LANE_W-1:0] slot_q,
  output logic [$clog2(DEPTH+1)-1:0]             fill_q
);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam int unsigned LW = i2c_dport_pkg::LANE_W;

  logic [CW-1:0] base;
  assign base = fill_q - CW'(pop_n);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [LW-1:0] d;
    logic [LW-1:0] q;
    always_comb begin
      d = '0;
      for (int k = 0; k < 3; k++) begin
        if (int'(pop_n) == k && i + k < DEPTH) d = slot_q[(i + k) % DEPTH];
      end
      if (push_n != 2'd0 && int'(base) == i) d = push_a;
      if (push_n == 2'd2 && int'(base) + 1 == i) d = push_b;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign slot_q[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_q - CW'(pop_n) + CW'(push_n);
  end
endmodule

// File: rtl/i2c_dport_flags.sv
module i2c_dport_flags #(
  parameter int unsigned W = i2c_dport_pkg::ST_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seq_set,
  input  logic [W-1:0] seq_clr,
  input  logic [W-1:0] acc_set,
  input  logic [W-1:0] acc_clr,
  output logic [W-1:0] flags_q
);
  logic [W-1:0] flags_d;
  always_comb begin
    flags_d = (flags_q & ~seq_clr) | seq_set;
    flags_d = (flags_d & ~acc_clr) | acc_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/i2c_dport.sv
module i2c_dport #(
  parameter int unsigned DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         big_endian,
  input  logic                         is_master,
  input  logic                         tx_dir,
  input  logic                         wr_en,
  input  logic                         wr_byte,
  input  logic [15:0]                  wr_data,
  input  logic                         rd_en,
  output logic [15:0]                  rd_data,
  input  logic                         rx_push,
  input  logic [7:0]                   rx_byte,
  input  logic                         tx_pop,
  output logic [7:0]                   tx_byte,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  input  logic [5:0]                   stat_set,
  input  logic [5:0]                   stat_clr,
  output logic [5:0]                   stat,
  output logic                         master_clr,
  output logic                         kick
);
  import i2c_dport_pkg::*;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [DEPTH-1:0][LANE_W-1:0] slots;
  logic [1:0]  need, push_n, pop_n;
  logic [LANE_W-1:0] push_a, push_b;
  logic        cpu_any, rd_go, rd_master;
  logic        ev_wr_ok, ev_wr_drop, ev_rd, ev_rd_empty, ev_push, ev_pop;
  logic        lock_q, lock_d;
  logic [CW-1:0] level_after;
  logic [ST_W-1:0] acc_set, acc_clr;
  logic [WORD_W-1:0] rd_word_q;
  logic        kick_q, mclr_q;

  // Access events, named for the checker.
  assign cpu_any     = wr_en | rd_en;
  assign rd_go       = rd_en & ~wr_en;
  assign rd_master   = rd_go & is_master & ~tx_dir;
  assign need        = wr_byte ? 2'd1 : 2'd2;
  assign ev_wr_ok    = wr_en & ~lock_q & ((int'(DEPTH) - int'(level)) >= int'(need));
  assign ev_wr_drop  = wr_en & ~ev_wr_ok;
  assign ev_rd       = rd_go & (level != '0);
  assign ev_rd_empty = rd_go & (level == '0);
  assign ev_push     = rx_push & ~cpu_any & (int'(level) < int'(DEPTH));
  assign ev_pop      = tx_pop & ~cpu_any & (level != '0);

  always_comb begin
    push_n = 2'd0;
    push_a = rx_byte;
    push_b = '0;
    if (ev_wr_ok) begin
      push_n = need;
      push_a = wr_byte ? wr_data[LANE_W-1:0] : lane_first(wr_data, big_endian);
      push_b = lane_second(wr_data, big_endian);
    end else if (ev_push) begin
      push_n = 2'd1;
    end
  end

  always_comb begin
    pop_n = 2'd0;
    if (ev_rd)       pop_n = (int'(level) >= 2) ? 2'd2 : 2'd1;
    else if (ev_pop) pop_n = 2'd1;
  end

  assign level_after = level - CW'(pop_n) + CW'(push_n);
  assign lock_d = (ev_wr_ok & wr_byte) | (lock_q & (level_after != '0));

  always_comb begin
    acc_set = '0;
    acc_clr = '0;
    if (rd_go) begin
      acc_clr[ST_RRDY] = 1'b1;
      acc_clr[ST_ROVR] = 1'b1;
    end
    if (rd_master) acc_set[ST_ARDY] = 1'b1;
    if (ev_wr_ok) begin
      acc_clr[ST_XUDF] = 1'b1;
      acc_clr[ST_XRDY] = 1'b1;
    end
    if (ev_rd_empty | ev_wr_drop) acc_set[ST_AERR] = 1'b1;
  end

  i2c_dport_buf #(.DEPTH(DEPTH)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .pop_n  (pop_n),
    .push_n (push_n),
    .push_a (push_a),
    .push_b (push_b),
    .slot_q (slots),
    .fill_q (level)
  );

  i2c_dport_flags #(.W(ST_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .seq_set (stat_set),
    .seq_clr (stat_clr),
    .acc_set (acc_set),
    .acc_clr (acc_clr),
    .flags_q (stat)
  );

  // Slots at or above the fill level always hold zero, so an empty or
  // half-empty read yields zero in the missing lanes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word_q <= '0;
      lock_q    <= 1'b0;
      kick_q    <= 1'b0;
      mclr_q    <= 1'b0;
    end else begin
      if (rd_go) rd_word_q <= word_of(slots[0], slots[1 % DEPTH], big_endian);
      lock_q <= lock_d;
      kick_q <= cpu_any;
      mclr_q <= rd_master;
    end
  end

  assign rd_data    = rd_word_q;
  assign tx_byte    = slots[0];
  assign kick       = kick_q;
  assign master_clr = mclr_q;
endmodule

// File: rtl/i2c_dport_chk.sv
module i2c_dport_chk #(
  parameter int unsigned DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic                       wr_byte,
  input logic                       is_master,
  input logic                       tx_dir,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic [5:0]                 stat,
  input logic [15:0]                rd_data,
  input logic                       kick,
  input logic                       master_clr,
  input logic                       ev_wr_ok,
  input logic                       ev_wr_drop,
  input logic                       ev_rd_empty
);
  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= int'(DEPTH));

  assert_word_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_ok && !wr_byte) |=> (int'(level) == int'($past(level)) + 2));

  assert_byte_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_ok && wr_byte) |=> (int'(level) == int'($past(level)) + 1));

  assert_drop_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_drop |=> ($stable(level) && stat[5]));

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_empty |=> (rd_data == 16'h0 && stat[5]));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> (!stat[1] && !stat[4]));

  assert_master_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && is_master && !tx_dir) |=> (master_clr && stat[0]));

  assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_ok |=> (!stat[2] && !stat[3]));

  assert_kick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> kick);

  assert_no_kick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |=> !kick);
endmodule

bind i2c_dport i2c_dport_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_i2c_dport.sv
module sim_i2c_dport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big_endian = 1'b0, is_master = 1'b0, tx_dir = 1'b0;
  logic wr_en = 1'b0, wr_byte = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic rx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_byte = '0;
  logic [7:0] tx_byte;
  logic [2:0] level;
  logic [5:0] stat_set = '0, stat_clr = '0;
  logic [5:0] stat;
  logic master_clr, kick;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  int unsigned mq[4];
  int mc;
  bit mlock;

  always #4 clk = ~clk;

  i2c_dport #(.DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .is_master(is_master),
    .tx_dir(tx_dir), .wr_en(wr_en), .wr_byte(wr_byte), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rx_push(rx_push), .rx_byte(rx_byte),
    .tx_pop(tx_pop), .tx_byte(tx_byte), .level(level), .stat_set(stat_set),
    .stat_clr(stat_clr), .stat(stat), .master_clr(master_clr), .kick(kick)
  );

  task automatic check(input string req, input string what, input int unsigned act, input int unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_drop(input int n);
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 3; j++) mq[j] = mq[j+1];
      mq[3] = 0;
      mc--;
    end
    if (mc == 0) mlock = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mc = 0; mlock = 0;
    for (int j = 0; j < 4; j++) mq[j] = 0;
  endtask

  task automatic push_rx(input int unsigned b);
    rx_push = 1'b1; rx_byte = 8'(b);
    @(negedge clk);
    rx_push = 1'b0;
    if (mc < 4) begin mq[mc] = b; mc++; end
    check("R10", "level after push", level, mc);
  endtask

  task automatic pop_tx(input string req);
    check(req, "tx_byte", tx_byte, mq[0]);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
    if (mc > 0) model_drop(1);
    check("R10", "level after pop", level, mc);
  endtask

  task automatic write_cpu(input int unsigned data, input bit isbyte, input string req);
    int need = isbyte ? 1 : 2;
    bit ok = !mlock && (4 - mc >= need);
    wr_en = 1'b1; wr_byte = isbyte; wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0; wr_byte = 1'b0;
    if (ok) begin
      if (isbyte) begin
        mq[mc] = data % 256; mc++; mlock = 1;
      end else if (big_endian) begin
        mq[mc] = (data / 256) % 256; mq[mc+1] = data % 256; mc += 2;
      end else begin
        mq[mc] = data % 256; mq[mc+1] = (data / 256) % 256; mc += 2;
      end
    end else begin
      check("R4", "access error after dropped write", stat[5], 1);
    end
    check(req, "level after write", level, mc);
    check("R9", "kick after write", kick, 1);
    @(negedge clk);
    check("R9", "kick idle", kick, 0);
  endtask

  task automatic read_cpu(input string req);
    int unsigned expw;
    bit mread = is_master && !tx_dir;
    if (big_endian) expw = mq[0] * 256 + mq[1];
    else            expw = mq[1] * 256 + mq[0];
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (mc == 0) check("R6", "access error on empty read", stat[5], 1);
    model_drop(mc >= 2 ? 2 : mc);
    check(req, "read word", rd_data, expw);
    check("R5", "level after read", level, mc);
    check("R7", "rx-ready/overrun cleared", {stat[4], stat[1]}, 0);
    check("R7", "master_clr", master_clr, mread);
    if (mread) check("R7", "access-ready set", stat[0], 1);
    check("R9", "kick after read", kick, 1);
    @(negedge clk);
    check("R7", "master_clr one cycle", master_clr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", "level", level, 0);
    check("R1", "stat", stat, 0);
    check("R1", "rd_data", rd_data, 0);
    check("R1", "kick", kick, 0);
    check("R1", "master_clr", master_clr, 0);

    // Read sweep: both lane orders, every fill level (R5, R6, R7)
    for (int be = 0; be < 2; be++) begin
      for (int n = 0; n <= 4; n++) begin
        big_endian = 1'(be);
        do_reset();
        is_master = 1'(n % 2); tx_dir = 1'((n / 2) % 2);
        for (int i = 0; i < n; i++) push_rx(16 * (n + 1) + i + 1 + 64 * be);
        stat_set = 6'h12;
        @(negedge clk);
        stat_set = '0;
        check("R11", "set rx flags", stat, 6'h12);
        while (mc > 0) read_cpu("R5");
        read_cpu("R6");
      end
    end
    is_master = 1'b0; tx_dir = 1'b1;

    // Write sweep: lane order x starting fill x word/byte (R2, R3, R4, R8)
    for (int be = 0; be < 2; be++) begin
      for (int pre = 0; pre <= 4; pre++) begin
        for (int kind = 0; kind < 2; kind++) begin
          bit ok;
          big_endian = 1'(be);
          do_reset();
          for (int i = 0; i < pre; i++) push_rx(8'h30 + i);
          stat_set = 6'h0C;
          @(negedge clk);
          stat_set = '0;
          ok = (4 - pre) >= (kind ? 1 : 2);
          write_cpu(32'hA000 + 256 * (pre + 1) + 16 * be + kind + 5, kind[0], kind ? "R3" : "R2");
          check("R8", "tx flags after write", {stat[3], stat[2]}, ok ? 0 : 3);
          while (mc > 0) pop_tx(kind ? "R3" : "R2");
          check("R2", "drained", level, 0);
        end
      end
    end

    // Lock after byte-wide write (R3)
    big_endian = 1'b0;
    do_reset();
    write_cpu(16'h1234, 1'b1, "R3");
    write_cpu(16'h5678, 1'b0, "R3");
    check("R3", "locked level", level, 1);
    pop_tx("R3");
    write_cpu(16'h9ABC, 1'b0, "R3");
    check("R3", "unlocked level", level, 2);
    pop_tx("R2"); pop_tx("R2");

    // Sequencer ignored during CPU access; push beyond full (R10)
    do_reset();
    rx_push = 1'b1; rx_byte = 8'h77; rd_en = 1'b1;
    @(negedge clk);
    rx_push = 1'b0; rd_en = 1'b0;
    check("R10", "push ignored during read", level, 0);
    check("R6", "empty read word", rd_data, 0);
    for (int i = 0; i < 5; i++) push_rx(8'h41 + i);
    check("R10", "full level", level, 4);
    pop_tx("R10"); pop_tx("R10");
    tx_pop = 1'b1; wr_en = 1'b1; wr_data = 16'hBEEF;
    @(negedge clk);
    tx_pop = 1'b0; wr_en = 1'b0;
    mq[mc] = 8'hEF; mq[mc+1] = 8'hBE; mc += 2;
    check("R10", "pop ignored during write", level, 4);
    while (mc > 0) pop_tx("R10");

    // Flag set/clear arithmetic (R11)
    do_reset();
    stat_set = 6'h3F; @(negedge clk); stat_set = '0;
    check("R11", "all set", stat, 6'h3F);
    stat_clr = 6'h15; @(negedge clk); stat_clr = '0;
    check("R11", "partial clear", stat, 6'h2A);
    stat_set = 6'h01; stat_clr = 6'h03; @(negedge clk);
    stat_set = '0; stat_clr = '0;
    check("R11", "set beats clear", stat, 6'h29);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule